// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two parallel buses, called side A and side B, through two storage registers that face opposite ways. The forward register captures side A and can present its contents on side B. The return register captures side B and can present its contents on side A. Each register has its own clock, its own active-low load enable and its own active-low output enable. The two directions share no control, so they may run from unrelated clocks.

Each bus appears on the core as a split triple: an input vector, an output vector and a single output-enable bit. The core therefore contains no internal tri-state nets, and the pad ring owns the tri-state drivers. A compile-time polarity switch selects whether the outputs carry the stored bits as they are or their complements. An optional synchronous clear, enabled by a parameter, gives each register a defined start value. Without it the register contents are undefined until the first load.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On a rising edge of `clk_a` with `ce_a_n` low, the forward register takes the value of `bus_a_in`.
- R2: While a register's load enable (`ce_a_n` or `ce_b_n`) is high, that register keeps its value across any number of edges of its clock, whatever its bus input does.
- R3: `bus_b_oe` equals the inverse of `oe_b_n`, and `bus_a_oe` equals the inverse of `oe_a_n`. While an output enable pin is high, the matching output vector is all zeros. Disabling an output does not alter the stored value.
- R4: On a rising edge of `clk_b` with `ce_b_n` low, the return register takes `bus_b_in`. While `oe_a_n` is low, it is presented on `bus_a_out`.
- R5: The two directions are independent. A load in one direction leaves the other register unchanged, and loads in both directions under unrelated clocks both complete.
- R6: With `INVERT`=0, an enabled output equals the stored value. With `INVERT`=1, each bit of an enabled output is the complement of the stored bit.
- R7: Bit n of `bus_a_in` reaches bit n of `bus_b_out`, and bit n of `bus_b_in` reaches bit n of `bus_a_out`. A value sent A to B and returned B to A arrives unchanged.
- R8: With `USE_SRST`=1, a rising edge of a register's clock with its clear input (`srst_a` or `srst_b`) high sets that register to zero, whatever its load enable is.
- R9: With `USE_SRST`=0, the clear inputs have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock of the forward (A to B) register |
| ce_a_n | input | 1 | Load enable of the forward register, active low |
| srst_a | input | 1 | Synchronous clear of the forward register, active high, honoured only when USE_SRST=1 |
| clk_b | input | 1 | Clock of the return (B to A) register |
| ce_b_n | input | 1 | Load enable of the return register, active low |
| srst_b | input | 1 | Synchronous clear of the return register, active high, honoured only when USE_SRST=1 |
| oe_a_n | input | 1 | Output enable of side A (return register), active low |
| oe_b_n | input | 1 | Output enable of side B (forward register), active low |
| bus_a_in | input | WIDTH | Value seen on side A |
| bus_a_out | output | WIDTH | Value driven onto side A |
| bus_a_oe | output | 1 | Drive enable for side A, active high |
| bus_b_in | input | WIDTH | Value seen on side B |
| bus_b_out | output | WIDTH | Value driven onto side B |
| bus_b_oe | output | 1 | Drive enable for side B, active high |

## Verification
The assertions check the following on every edge of each clock:
- load, hold and clear for each register;
- that each drive enable mirrors its pin;
- that an enabled output shows the stored word in the chosen polarity, and a disabled output shows zeros.

Only the bench's scenarios can show the following:
- that both directions complete loads under unrelated clocks at the same time;
- that bits keep their positions through a full A-to-B-to-A loopback;
- that a clear input is ignored when the clear is compiled out.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Output polarity selected at compile time
    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_INV  = 1'b1
    } pol_e;

endpackage

// File: rtl/xcvr_store.sv
// One direction's storage register: load on enable, hold otherwise,
// optional synchronous clear with priority over the load.
module xcvr_store #(
    parameter int WIDTH    = 8,
    parameter bit USE_SRST = 1'b0
) (
    input  logic             clk,
    input  logic             ce_n,
    input  logic             srst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } store_st_t;

    store_st_t st_d;
    store_st_t st_q;
    logic      clear;

    assign clear = USE_SRST && srst;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.data = '0;
        end else if (!ce_n) begin
            st_d.data = d;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.data;

endmodule

// File: rtl/xcvr_drive.sv
// Output gating for one bus side: polarity plus enable, zeros when idle.
module xcvr_drive #(
    parameter int             WIDTH = 8,
    parameter xcvr_pkg::pol_e POL   = xcvr_pkg::POL_TRUE
) (
    input  logic [WIDTH-1:0] q,
    input  logic             oe_n,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe
);

    logic [WIDTH-1:0] shaped;

    generate
        if (POL == xcvr_pkg::POL_INV) begin : g_inv
            assign shaped = ~q;
        end else begin : g_true
            assign shaped = q;
        end
    endgenerate

    assign bus_oe  = ~oe_n;
    assign bus_out = oe_n ? '0 : shaped;

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
    parameter int WIDTH    = 8,
    parameter bit INVERT   = 1'b0,
    parameter bit USE_SRST = 1'b0
) (
    input  logic             clk_a,
    input  logic             ce_a_n,
    input  logic             srst_a,
    input  logic             clk_b,
    input  logic             ce_b_n,
    input  logic             srst_b,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] bus_a_in,
    output logic [WIDTH-1:0] bus_a_out,
    output logic             bus_a_oe,
    input  logic [WIDTH-1:0] bus_b_in,
    output logic [WIDTH-1:0] bus_b_out,
    output logic             bus_b_oe
);

    localparam xcvr_pkg::pol_e POL_SEL = INVERT ? xcvr_pkg::POL_INV : xcvr_pkg::POL_TRUE;

    logic [WIDTH-1:0] a_q;   // forward register, captured from side A
    logic [WIDTH-1:0] b_q;   // return register, captured from side B

    xcvr_store #(.WIDTH(WIDTH), .USE_SRST(USE_SRST)) u_fwd_store (
        .clk  (clk_a),
        .ce_n (ce_a_n),
        .srst (srst_a),
        .d    (bus_a_in),
        .q    (a_q)
    );

    xcvr_store #(.WIDTH(WIDTH), .USE_SRST(USE_SRST)) u_ret_store (
        .clk  (clk_b),
        .ce_n (ce_b_n),
        .srst (srst_b),
        .d    (bus_b_in),
        .q    (b_q)
    );

    xcvr_drive #(.WIDTH(WIDTH), .POL(POL_SEL)) u_drive_b (
        .q       (a_q),
        .oe_n    (oe_b_n),
        .bus_out (bus_b_out),
        .bus_oe  (bus_b_oe)
    );

    xcvr_drive #(.WIDTH(WIDTH), .POL(POL_SEL)) u_drive_a (
        .q       (b_q),
        .oe_n    (oe_a_n),
        .bus_out (bus_a_out),
        .bus_oe  (bus_a_oe)
    );

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int WIDTH    = 8,
    parameter bit INVERT   = 1'b0,
    parameter bit USE_SRST = 1'b0
) (
    input logic             clk_a,
    input logic             ce_a_n,
    input logic             srst_a,
    input logic             clk_b,
    input logic             ce_b_n,
    input logic             srst_b,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic [WIDTH-1:0] bus_a_in,
    input logic [WIDTH-1:0] bus_a_out,
    input logic             bus_a_oe,
    input logic [WIDTH-1:0] bus_b_in,
    input logic [WIDTH-1:0] bus_b_out,
    input logic             bus_b_oe,
    input logic [WIDTH-1:0] a_q,
    input logic [WIDTH-1:0] b_q
);

    logic clr_a;
    logic clr_b;
    logic known_a;
    logic known_b;

    assign clr_a = USE_SRST && srst_a;
    assign clr_b = USE_SRST && srst_b;

    // A register holds a defined value once it has been loaded or cleared
    always_ff @(posedge clk_a) known_a <= known_a | !ce_a_n | clr_a;
    always_ff @(posedge clk_b) known_b <= known_b | !ce_b_n | clr_b;

    AST_A_LOAD: assert property (@(posedge clk_a) disable iff (clr_a)
        (!ce_a_n && !clr_a) |=> (a_q == $past(bus_a_in)));                 // R1
    AST_A_HOLD: assert property (@(posedge clk_a) disable iff (clr_a)
        (known_a && ce_a_n && !clr_a) |=> $stable(a_q));                    // R2
    AST_B_LOAD: assert property (@(posedge clk_b) disable iff (clr_b)
        (!ce_b_n && !clr_b) |=> (b_q == $past(bus_b_in)));                 // R4
    AST_B_HOLD: assert property (@(posedge clk_b) disable iff (clr_b)
        (known_b && ce_b_n && !clr_b) |=> $stable(b_q));                    // R2
    AST_A_CLEAR: assert property (@(posedge clk_a) disable iff (!known_a)
        clr_a |=> (a_q == '0));                                             // R8
    AST_B_CLEAR: assert property (@(posedge clk_b) disable iff (!known_b)
        clr_b |=> (b_q == '0));                                             // R8
    AST_B_OE_PIN: assert property (@(posedge clk_a) disable iff (clr_a)
        bus_b_oe == !oe_b_n);                                               // R3
    AST_A_OE_PIN: assert property (@(posedge clk_b) disable iff (clr_b)
        bus_a_oe == !oe_a_n);                                               // R3
    AST_B_IDLE_ZERO: assert property (@(posedge clk_a) disable iff (clr_a)
        oe_b_n |-> (bus_b_out == '0));                                      // R3
    AST_A_IDLE_ZERO: assert property (@(posedge clk_b) disable iff (clr_b)
        oe_a_n |-> (bus_a_out == '0));                                      // R3
    AST_B_POLARITY: assert property (@(posedge clk_a) disable iff (clr_a)
        (known_a && !oe_b_n) |-> (bus_b_out == (INVERT ? ~a_q : a_q)));     // R6
    AST_A_POLARITY: assert property (@(posedge clk_b) disable iff (clr_b)
        (known_b && !oe_a_n) |-> (bus_a_out == (INVERT ? ~b_q : b_q)));     // R6

endmodule

bind dual_reg_xcvr xcvr_chk #(
    .WIDTH    (WIDTH),
    .INVERT   (INVERT),
    .USE_SRST (USE_SRST)
) u_chk (
    .clk_a     (clk_a),
    .ce_a_n    (ce_a_n),
    .srst_a    (srst_a),
    .clk_b     (clk_b),
    .ce_b_n    (ce_b_n),
    .srst_b    (srst_b),
    .oe_a_n    (oe_a_n),
    .oe_b_n    (oe_b_n),
    .bus_a_in  (bus_a_in),
    .bus_a_out (bus_a_out),
    .bus_a_oe  (bus_a_oe),
    .bus_b_in  (bus_b_in),
    .bus_b_out (bus_b_out),
    .bus_b_oe  (bus_b_oe),
    .a_q       (a_q),
    .b_q       (b_q)
);

// File: tb/dual_reg_xcvr_tb.sv
module dual_reg_xcvr_tb;

    localparam int W = 8;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    always #2 clk_a = ~clk_a;     // 250 MHz
    always #3.5 clk_b = ~clk_b;   // unrelated second domain

    logic         ce_a_n = 1'b1, ce_b_n = 1'b1;
    logic         srst_a = 1'b0, srst_b = 1'b0;
    logic         oe_a_n = 1'b0, oe_b_n = 1'b0;
    logic [W-1:0] bus_a_in = '0, bus_b_in = '0;

    logic [W-1:0] a_out_d, b_out_d, a_out_i, b_out_i;
    logic         a_oe_d, b_oe_d, a_oe_i, b_oe_i;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    dual_reg_xcvr #(.WIDTH(W), .INVERT(1'b0), .USE_SRST(1'b1)) u_dut (
        .clk_a(clk_a), .ce_a_n(ce_a_n), .srst_a(srst_a),
        .clk_b(clk_b), .ce_b_n(ce_b_n), .srst_b(srst_b),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .bus_a_in(bus_a_in), .bus_a_out(a_out_d), .bus_a_oe(a_oe_d),
        .bus_b_in(bus_b_in), .bus_b_out(b_out_d), .bus_b_oe(b_oe_d)
    );

    dual_reg_xcvr #(.WIDTH(W), .INVERT(1'b1), .USE_SRST(1'b0)) u_inv (
        .clk_a(clk_a), .ce_a_n(ce_a_n), .srst_a(srst_a),
        .clk_b(clk_b), .ce_b_n(ce_b_n), .srst_b(srst_b),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .bus_a_in(bus_a_in), .bus_a_out(a_out_i), .bus_a_oe(a_oe_i),
        .bus_b_in(bus_b_in), .bus_b_out(b_out_i), .bus_b_oe(b_oe_i)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Load the forward register; returns after the capturing edge
    task automatic load_a(input logic [W-1:0] v);
        @(negedge clk_a);
        bus_a_in = v;
        ce_a_n   = 1'b0;
        @(negedge clk_a);
        ce_a_n   = 1'b1;
    endtask

    task automatic load_b(input logic [W-1:0] v);
        @(negedge clk_b);
        bus_b_in = v;
        ce_b_n   = 1'b0;
        @(negedge clk_b);
        ce_b_n   = 1'b1;
    endtask

    task automatic t_clear();
        @(negedge clk_a); srst_a = 1'b1; ce_a_n = 1'b0; bus_a_in = 8'hFF;
        @(negedge clk_a); srst_a = 1'b0; ce_a_n = 1'b1;
        @(negedge clk_b); srst_b = 1'b1;
        @(negedge clk_b); srst_b = 1'b0;
        chk("R8 clear beats load, side B out", b_out_d, 8'h00);
        chk("R8 clear, side A out", a_out_d, 8'h00);
        chk("R3 side B enable", {7'd0, b_oe_d}, 8'h01);
    endtask

    task automatic t_load_a();
        load_a(8'hA5);
        chk("R1 forward load", b_out_d, 8'hA5);
        chk("R6 inverted forward out", b_out_i, 8'h5A);
    endtask

    task automatic t_hold();
        bus_a_in = 8'h3C;
        bus_b_in = 8'hC3;
        repeat (6) @(negedge clk_a);
        chk("R2 forward hold", b_out_d, 8'hA5);
        chk("R2 return hold", a_out_d, 8'h00);
    endtask

    task automatic t_oe();
        @(negedge clk_a); oe_b_n = 1'b1;
        #1;
        chk("R3 B disabled enable", {7'd0, b_oe_d}, 8'h00);
        chk("R3 B disabled data", b_out_d, 8'h00);
        chk("R3 B disabled inverted data", b_out_i, 8'h00);
        @(negedge clk_a); oe_b_n = 1'b0;
        #1;
        chk("R3 B re-enabled keeps value", b_out_d, 8'hA5);
        oe_a_n = 1'b1;
        #1;
        chk("R3 A disabled enable", {7'd0, a_oe_d}, 8'h00);
        oe_a_n = 1'b0;
    endtask

    task automatic t_load_b();
        load_b(8'h5A);
        chk("R4 return load", a_out_d, 8'h5A);
        chk("R6 inverted return out", a_out_i, 8'hA5);
        chk("R5 forward untouched", b_out_d, 8'hA5);
    endtask

    task automatic t_simul();
        fork
            load_a(8'h11);
            load_b(8'hE7);
        join
        @(negedge clk_a);
        chk("R5 simultaneous forward", b_out_d, 8'h11);
        chk("R5 simultaneous return", a_out_d, 8'hE7);
    endtask

    task automatic t_walk();
        for (int i = 0; i < W; i++) begin
            load_a(W'(1) << i);
            chk("R7 bit position forward", b_out_d, W'(1) << i);
        end
        load_b(8'h40);
        chk("R7 bit position return", a_out_d, 8'h40);
    endtask

    task automatic t_loop();
        logic [W-1:0] seen;
        load_a(8'h96);
        seen = b_out_d;
        load_b(seen);
        chk("R7 loopback A to B to A", a_out_d, 8'h96);
    endtask

    task automatic t_clear_ignored();
        // both units hold 96 forward; clear with enable high
        @(negedge clk_a); srst_a = 1'b1;
        @(negedge clk_a); srst_a = 1'b0;
        chk("R9 clear ignored when compiled out", b_out_i, 8'h69);
        chk("R8 clear applied when compiled in", b_out_d, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk_a);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk_a);
        t_clear();
        t_load_a();
        t_hold();
        t_oe();
        t_load_b();
        t_simul();
        t_walk();
        t_loop();
        t_clear_ignored();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule